// File: doc/BRIEF.md
# Flash Erase/Program Command Sequencer with Key Unlock

This block sits between a processor's register bus and the control side of an on-chip program flash. Software sets up an operation in a control register, loads a page number and an in-page word offset, writes a two-word key, and then sets a start bit. The block launches a page erase or a row program toward the flash array only when that start write directly follows a correct key pair. During the operation, a stall output holds the processor. The start bit clears by itself when the operation's timed length has run out.

Two parameters set the erase and program durations in clock cycles. These counts stand in for the array's real timing. The flash array itself, its write latches and its analog supplies lie outside this block.

Bus map (word addresses on `bus_addr`): 0 = control, 1 = key, 2 = page, 3 = in-page offset.

Top module: `nvm_unlock_seq`

## Requirements
- R1: After reset, the control register reads 0x0000, and `stall_o`, `done_o`, `fl_erase_o` and `fl_prog_o` are all low.
- R2: The control register holds the operation code in bits [3:0], erase-select in bit 6, the error flag in bit 13, write-enable in bit 14 and start in bit 15. A write made while idle stores bits [3:0], 6 and 14, and these read back unchanged.
- R3: A control write with bits 15 and 14 set launches an operation when the two bus writes just before it were key 0x0055 followed by key 0x00AA. `stall_o` rises on the cycle after that write.
- R4: A start with bit 14 set that lacks this unlock launches nothing and sets error bit 13. The unlock is missing when the keys came in the wrong order, or when any other bus write came between or after the keys.
- R5: A start write with bit 14 clear is ignored. No operation launches and the error bit is not set.
- R6: Only two operation codes are valid: 4'b0010 with bit 6 set (page erase) and 4'b0001 with bit 6 clear (row program). Any other combination on a start sets the error bit and launches nothing.
- R7: Writing 1 to bit 13 of the control register clears the error flag. Writing 0 to bit 13 leaves it set.
- R8: A page erase raises `fl_erase_o` with `fl_addr_o` = {page, 9'b0}, for exactly ERASE_CYCLES cycles.
- R9: A row program raises `fl_prog_o` with `fl_addr_o` = {page, offset[8:6], 6'b0}, for exactly PROG_CYCLES cycles. The address stays stable throughout the operation.
- R10: When the operation ends, the start bit reads 0 again, `stall_o` falls, and `done_o` pulses high for one cycle on that same cycle.
- R11: Control writes made while busy have no effect. After each launched operation the unlock is consumed, so a later start needs a fresh key pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| stall_o | output | 1 | Processor stall while an operation runs |
| done_o | output | 1 | One-cycle pulse at operation end |
| fl_erase_o | output | 1 | Page-erase command to the array |
| fl_prog_o | output | 1 | Row-program command to the array |
| fl_addr_o | output | PAGE_W+9 | Word address of the page or row |

## Verification
The key sequence is tried in five patterns: the correct pair, the reversed pair, the pair with a page write placed between the two keys, a start issued after an operation with no new keys, and the correct pair followed by a start with write-enable clear. Together these separate a real unlock from a stale one, a misordered one and a broken one, and they separate the silent-ignore case from the error case. Both operation kinds run at distinct page and offset values, so a wrong row slice or a swapped duration shows up in the address or the stall length. Reserved codes, including the program code paired with erase-select, confirm that only the two legal combinations launch anything.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    localparam logic [1:0]  REG_CTRL = 2'd0;
    localparam logic [1:0]  REG_KEY  = 2'd1;
    localparam logic [1:0]  REG_PAGE = 2'd2;
    localparam logic [1:0]  REG_OFFS = 2'd3;

    localparam logic [15:0] KEY_FIRST  = 16'h0055;
    localparam logic [15:0] KEY_SECOND = 16'h00AA;

    localparam logic [3:0]  OP_PAGE_ERASE = 4'b0010;
    localparam logic [3:0]  OP_ROW_PROG   = 4'b0001;

    localparam int BIT_START = 15;
    localparam int BIT_WREN  = 14;
    localparam int BIT_ERR   = 13;
    localparam int BIT_ERSEL = 6;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_HALF = 2'd1,
        KS_OPEN = 2'd2
    } key_state_e;

    function automatic logic op_is_legal(input logic [3:0] op, input logic ersel);
        return (op == OP_PAGE_ERASE && ersel) || (op == OP_ROW_PROG && !ersel);
    endfunction

endpackage

// File: rtl/nvm_key_fsm.sv
module nvm_key_fsm
    import nvm_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic        key_sel_i,
    input  logic [15:0] wdata_i,
    input  logic        busy_i,
    output logic        unlocked_o
);

    key_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy_i) begin
            st_d = KS_IDLE;
        end else if (wr_i) begin
            if (key_sel_i && wdata_i == KEY_FIRST && st_q != KS_HALF)
                st_d = KS_HALF;
            else if (key_sel_i && wdata_i == KEY_SECOND && st_q == KS_HALF)
                st_d = KS_OPEN;
            else
                st_d = KS_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KS_IDLE;
        else        st_q <= st_d;
    end

    assign unlocked_o = (st_q == KS_OPEN);

    // R3: the open state is reached only through the second key write
    p_open_after_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == KS_OPEN && $past(st_q) != KS_OPEN) |->
            $past(wr_i && key_sel_i && wdata_i == KEY_SECOND));

    // R11: an operation in progress always drops the unlock
    p_lock_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> st_q == KS_IDLE);

endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
    parameter int ERASE_CYCLES = 400,
    parameter int PROG_CYCLES  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic is_erase_i,
    output logic busy_o,
    output logic erase_o,
    output logic done_o
);

    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic             busy;
        logic             erase;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.busy) begin
            if (r_q.cnt == '0) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            r_d.busy  = 1'b1;
            r_d.erase = is_erase_i;
            r_d.cnt   = is_erase_i ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o  = r_q.busy;
    assign erase_o = r_q.erase;
    assign done_o  = r_q.done;

    // R8, R9: the remaining count never exceeds the selected duration
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (32'(r_q.cnt) < (erase_o ? ERASE_CYCLES : PROG_CYCLES)));

    // R10: done fires only as busy falls
    p_done_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/nvm_unlock_seq.sv
module nvm_unlock_seq
    import nvm_seq_pkg::*;
#(
    parameter int PAGE_W       = 7,
    parameter int ERASE_CYCLES = 400,
    parameter int PROG_CYCLES  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              stall_o,
    output logic              done_o,
    output logic              fl_erase_o,
    output logic              fl_prog_o,
    output logic [PAGE_W+8:0] fl_addr_o
);

    localparam int ADDR_W = PAGE_W + 9;
    localparam int OFFS_W = 9;
    localparam int ROW_LSB = 6;

    typedef struct packed {
        logic [3:0]        op;
        logic              ersel;
        logic              wren;
        logic              err;
        logic [PAGE_W-1:0] page;
        logic [OFFS_W-1:0] offs;
        logic [ADDR_W-1:0] addr;
    } regs_t;

    regs_t r_d, r_q;

    logic busy, tmr_erase, unlocked;
    logic ctrl_wr, start_req, legal, launch;

    nvm_key_fsm u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .key_sel_i (bus_addr == REG_KEY),
        .wdata_i   (bus_wdata),
        .busy_i    (busy),
        .unlocked_o(unlocked)
    );

    nvm_op_timer #(
        .ERASE_CYCLES(ERASE_CYCLES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (launch),
        .is_erase_i(bus_wdata[BIT_ERSEL]),
        .busy_o    (busy),
        .erase_o   (tmr_erase),
        .done_o    (done_o)
    );

    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == REG_CTRL) && !busy;
        start_req = ctrl_wr && bus_wdata[BIT_START] && bus_wdata[BIT_WREN];
        legal     = op_is_legal(bus_wdata[3:0], bus_wdata[BIT_ERSEL]);
        launch    = start_req && unlocked && legal;

        r_d = r_q;
        if (ctrl_wr) begin
            r_d.op    = bus_wdata[3:0];
            r_d.ersel = bus_wdata[BIT_ERSEL];
            r_d.wren  = bus_wdata[BIT_WREN];
            if (bus_wdata[BIT_ERR]) r_d.err = 1'b0;
            if (start_req && !launch) r_d.err = 1'b1;
        end
        if (bus_wr && bus_addr == REG_PAGE) r_d.page = bus_wdata[PAGE_W-1:0];
        if (bus_wr && bus_addr == REG_OFFS) r_d.offs = bus_wdata[OFFS_W-1:0];
        if (launch) begin
            if (bus_wdata[BIT_ERSEL])
                r_d.addr = {r_q.page, {OFFS_W{1'b0}}};
            else
                r_d.addr = {r_q.page, r_q.offs[OFFS_W-1:ROW_LSB], {ROW_LSB{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = {busy, r_q.wren, r_q.err, 6'b0, r_q.ersel, 2'b0, r_q.op};
            REG_PAGE: bus_rdata = {{(16-PAGE_W){1'b0}}, r_q.page};
            REG_OFFS: bus_rdata = {{(16-OFFS_W){1'b0}}, r_q.offs};
            default:  bus_rdata = 16'h0000;
        endcase
    end

    assign stall_o    = busy;
    assign fl_erase_o = busy && tmr_erase;
    assign fl_prog_o  = busy && !tmr_erase;
    assign fl_addr_o  = r_q.addr;

    // R4: an operation only begins right after an unlock
    p_start_needs_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(unlocked));

    // R8: at most one command line is active, and only while stalled
    p_cmd_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_erase_o && fl_prog_o) && ((fl_erase_o || fl_prog_o) == stall_o));

    // R9: the address holds for the whole operation
    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && $past(stall_o)) |-> $stable(fl_addr_o));

    // R11: control fields are frozen while busy
    p_ctrl_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && $past(stall_o)) |-> ($stable(r_q.op) && $stable(r_q.wren) && $stable(r_q.err)));

endmodule

// File: tb/nvm_unlock_seq_bench.sv
module nvm_unlock_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ER_CYC     = 20;
    localparam int PG_CYC     = 7;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        stall_o, done_o, fl_erase_o, fl_prog_o;
    logic [15:0] fl_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic        er;
        logic [15:0] addr;
        logic [31:0] len;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_unlock_seq #(
        .PAGE_W(7), .ERASE_CYCLES(ER_CYC), .PROG_CYCLES(PG_CYC)
    ) u_nvm_unlock_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stall_o(stall_o),
        .done_o(done_o), .fl_erase_o(fl_erase_o), .fl_prog_o(fl_prog_o),
        .fl_addr_o(fl_addr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [15:0] expv);
        bus_addr = a;
        #1;
        check(req, {16'h0, bus_rdata}, {16'h0, expv});
    endtask

    task automatic unlock();
        wr(2'd1, 16'h0055);
        wr(2'd1, 16'h00AA);
    endtask

    task automatic wait_idle();
        while (stall_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic expect_op(input logic er, input logic [15:0] a, input int n);
        exp_t e;
        e.er = er; e.addr = a; e.len = 32'(n);
        exp_q.push_back(e);
    endtask

    task automatic no_launch(input string req);
        check(req, {31'h0, stall_o}, 32'h0);
        repeat (3) @(negedge clk);
        check(req, {31'h0, stall_o}, 32'h0);
    endtask

    // monitor: measures each operation and compares against the queue
    logic        prev_stall = 1'b0;
    logic        mon_er = 1'b0;
    logic [15:0] mon_addr = 16'h0;
    int          mon_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_o && !prev_stall) begin
                mon_er = fl_erase_o; mon_addr = fl_addr_o; mon_len = 0;
            end
            if (stall_o) begin
                mon_len++;
                if (fl_addr_o !== mon_addr) check("R9 addr drift", {16'h0, fl_addr_o}, {16'h0, mon_addr});
            end
            if (done_o) begin
                check("R10 stall low with done", {31'h0, stall_o}, 32'h0);
                if (exp_q.size() == 0) begin
                    check("R3 unexpected operation", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.er ? "R8 kind" : "R9 kind", {31'h0, mon_er}, {31'h0, e.er});
                    check(e.er ? "R8 addr" : "R9 addr", {16'h0, mon_addr}, {16'h0, e.addr});
                    check(e.er ? "R8 length" : "R9 length", 32'(mon_len), e.len);
                end
            end
            if (prev_stall && !stall_o)
                check("R10 done on fall", {31'h0, done_o}, 32'h1);
            prev_stall = stall_o;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd_check("R1 ctrl", 2'd0, 16'h0000);
        check("R1 stall", {31'h0, stall_o}, 32'h0);
        check("R1 cmds", {30'h0, fl_erase_o, fl_prog_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", {31'h0, done_o}, 32'h0);

        // R2 field storage without start
        wr(2'd0, 16'h4042);
        rd_check("R2 ctrl readback", 2'd0, 16'h4042);
        wr(2'd2, 16'h0005);
        wr(2'd3, 16'h01C7);
        rd_check("R2 page readback", 2'd2, 16'h0005);
        rd_check("R2 offset readback", 2'd3, 16'h01C7);

        // R3/R8 page erase
        expect_op(1'b1, 16'h0A00, ER_CYC);
        unlock();
        wr(2'd0, 16'hC042);
        check("R3 stall after start", {31'h0, stall_o}, 32'h1);
        check("R8 erase line", {31'h0, fl_erase_o}, 32'h1);
        // R11 writes while busy
        wr(2'd0, 16'h2000);
        rd_check("R11 ctrl frozen", 2'd0, 16'hC042);
        wait_idle();
        rd_check("R10 start cleared", 2'd0, 16'h4042);

        // R9 row program, offset row 7
        expect_op(1'b0, 16'h0BC0, PG_CYC);
        unlock();
        wr(2'd0, 16'hC001);
        check("R9 prog line", {31'h0, fl_prog_o}, 32'h1);
        wait_idle();

        // R11 unlock consumed
        wr(2'd0, 16'hC001);
        no_launch("R11 no relaunch");
        rd_check("R11 error set", 2'd0, 16'h6001);

        // R7 clear semantics
        wr(2'd0, 16'h4001);
        rd_check("R7 zero keeps error", 2'd0, 16'h6001);
        wr(2'd0, 16'h6001);
        rd_check("R7 one clears error", 2'd0, 16'h4001);

        // R4 reversed keys
        wr(2'd1, 16'h00AA);
        wr(2'd1, 16'h0055);
        wr(2'd0, 16'hC001);
        no_launch("R4 reversed keys");
        rd_check("R4 reversed error", 2'd0, 16'h6001);
        wr(2'd0, 16'h6001);

        // R4 intervening write
        wr(2'd1, 16'h0055);
        wr(2'd2, 16'h0003);
        wr(2'd1, 16'h00AA);
        wr(2'd0, 16'hC001);
        no_launch("R4 broken sequence");
        rd_check("R4 broken error", 2'd0, 16'h6001);
        wr(2'd0, 16'h6001);

        // R5 write-enable clear
        unlock();
        wr(2'd0, 16'h8001);
        no_launch("R5 no wren");
        rd_check("R5 no error", 2'd0, 16'h0001);

        // R6 reserved codes
        unlock();
        wr(2'd0, 16'hC003);
        no_launch("R6 reserved op");
        rd_check("R6 error", 2'd0, 16'h6003);
        wr(2'd0, 16'h6001);
        unlock();
        wr(2'd0, 16'hC041);
        no_launch("R6 program with erase bit");
        rd_check("R6 error 2", 2'd0, 16'h6041);
        wr(2'd0, 16'h6001);

        // R9 second program at page 3, row 1
        wr(2'd3, 16'h0040);
        expect_op(1'b0, 16'h0640, PG_CYC);
        unlock();
        wr(2'd0, 16'hC001);
        wait_idle();

        repeat (3) @(negedge clk);
        check("R3 all operations seen", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule